// File: doc/BRIEF.md
# Resource hazard tracking table

This block keeps a small associative table of buffers that a rendering pipe is still using, so that a second pipe running ahead on binning work can tell when touching one of those buffers would be unsafe. Each live entry holds an opaque base handle, a write flag and the timestamp of its most recent use. The handle is only ever compared for equality and is never treated as an address.

Three kinds of request arrive. An add request from the binning side records a buffer in the table. A check request asks whether a binning-side access would collide with a live entry. A clear request carries a completion timestamp and retires every entry whose timestamp is no later than that value. A check raises `stall` in the same cycle whenever a conflict exists, and the requester holds the check until `stall` drops. When an add finds no room, the entry is dropped and a sticky overflow bit is set. That bit tells the next binning pass to wait for rendering to finish. Software clears it by writing 0.

Top module: `res_hazard_table`

## Requirements
- R1: After reset the table is empty, `stall` is 0 and `ovfFlag` is 0.
- R2: While `chkValid` is 1, `stall` is 1 in the same cycle if some live entry has a base equal to `chkBase` and either `chkWrite` or that entry's write flag is 1. An added entry takes part in checks from the cycle after the add.
- R3: A check whose base matches only read entries and is itself a read, or whose base matches no live entry, gives `stall` 0. `stall` is 0 whenever `chkValid` is 0.
- R4: An add whose base equals a live entry's base does not take a new slot. It replaces that entry's timestamp with `addTs` and ORs `addWrite` into its write flag. An add whose base matches no live entry takes the lowest-numbered free slot.
- R5: A cycle with `clrValid` 1 removes every live entry whose timestamp is less than or equal to `clrTs`, compared as unsigned. Entries with a larger timestamp stay.
- R6: When a clear and a check occur in the same cycle, `stall` is evaluated against the table with that clear already applied.
- R7: An add that matches no live entry while all slots are occupied is dropped, and `ovfFlag` becomes 1 on the next cycle. Occupancy is judged before any clear in the same cycle.
- R8: `ovfFlag` stays 1 until a cycle with `ovfWrEn` 1 and `ovfWrData` 0. A write of 1 has no effect. A new overflow in the same cycle as a clearing write leaves the flag at 1.
- R9: Base handles are compared over all `BASE_W` bits, so handles that differ only in the top bit do not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| addValid | input | 1 | Add request strobe |
| addBase | input | BASE_W | Base handle to record |
| addWrite | input | 1 | Add request writes the buffer |
| addTs | input | TS_W | Use timestamp of the add |
| chkValid | input | 1 | Check request, held while stalled |
| chkBase | input | BASE_W | Base handle to check |
| chkWrite | input | 1 | Checked access writes the buffer |
| clrValid | input | 1 | Bulk clear request |
| clrTs | input | TS_W | Completion timestamp for the clear |
| ovfWrEn | input | 1 | Software write to the overflow bit |
| ovfWrData | input | 1 | Written value; 0 clears the bit |
| stall | output | 1 | Check conflicts with a live entry |
| ovfFlag | output | 1 | Sticky overflow; binning must wait for rendering |

## Verification
The hardest situation to reach is an add that finds every slot occupied, because it needs sixteen distinct live handles and then a seventeenth new one. The stimulus fills the table with a loop of distinct handles and re-adds one of them, which must merge and leave the flag clear. A new handle then overflows. Later the bench sends an overflowing add in the same cycle as a clear that would empty the table, and in the same cycle as a software clearing write, which separates occupancy before and after the clear and shows which update takes priority.

// File: rtl/rht_pkg.sv
package rht_pkg;
  // Strobes from control to the entry store.
  typedef struct packed {
    logic wrEn;    // write an entry this cycle
    logic merge;   // update a live entry instead of filling a free one
    logic setOvf;  // add dropped because the table is full
  } rhtStrobe_t;
endpackage

// File: rtl/rht_store.sv
module rht_store
  import rht_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int BASE_W  = 64,
  parameter int TS_W    = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [BASE_W-1:0]  addBase,
  input  logic               addWrite,
  input  logic [TS_W-1:0]    addTs,
  input  logic [BASE_W-1:0]  chkBase,
  input  logic               chkWrite,
  input  logic               clrValid,
  input  logic [TS_W-1:0]    clrTs,
  input  rhtStrobe_t         strobe,
  input  logic [IDX_W-1:0]   wrIdx,
  output logic [ENTRIES-1:0] freeVec,
  output logic [ENTRIES-1:0] matchVec,
  output logic [ENTRIES-1:0] hitVec
);

  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] clrHit;
  logic [ENTRIES-1:0] liveVec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    logic              vld;
    logic              wrFlag;
    logic [BASE_W-1:0] base;
    logic [TS_W-1:0]   ts;
    logic              sel;

    assign sel         = strobe.wrEn && (wrIdx == IDX_W'(i));
    assign validVec[i] = vld;
    assign clrHit[i]   = vld && clrValid && (ts <= clrTs);
    // Clear is applied before any same-cycle lookup.
    assign liveVec[i]  = vld && !clrHit[i];
    assign freeVec[i]  = !vld;
    assign matchVec[i] = liveVec[i] && (base == addBase);
    assign hitVec[i]   = liveVec[i] && (base == chkBase) && (wrFlag || chkWrite);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vld    <= 1'b0;
        wrFlag <= 1'b0;
        base   <= '0;
        ts     <= '0;
      end else begin
        if (clrHit[i]) vld <= 1'b0;
        if (sel) begin
          vld <= 1'b1;
          ts  <= addTs;
          if (strobe.merge) begin
            wrFlag <= wrFlag | addWrite;
          end else begin
            base   <= addBase;
            wrFlag <= addWrite;
          end
        end
      end
    end
  end

  // R4: a handle is never live in two slots at once.
  p_unique_base_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));

  // R4: a fresh entry only lands in an unoccupied slot.
  p_fresh_slot_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !strobe.merge) |-> !validVec[wrIdx]);

  // R5: an entry hit by a clear and not rewritten is gone next cycle.
  p_clear_done_r5: assert property (@(posedge clk) disable iff (!rstN)
    (clrHit[0] && !(strobe.wrEn && wrIdx == '0)) |=> !validVec[0]);

endmodule

// File: rtl/rht_ctrl.sv
module rht_ctrl
  import rht_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               addValid,
  input  logic               chkValid,
  input  logic               ovfWrEn,
  input  logic               ovfWrData,
  input  logic [ENTRIES-1:0] freeVec,
  input  logic [ENTRIES-1:0] matchVec,
  input  logic [ENTRIES-1:0] hitVec,
  output rhtStrobe_t         strobe,
  output logic [IDX_W-1:0]   wrIdx,
  output logic               stall,
  output logic               ovfFlag
);

  logic [IDX_W-1:0] freeIdx;
  logic [IDX_W-1:0] matchIdx;
  logic             anyFree;
  logic             anyMatch;

  // Lowest-index priority pick for both vectors.
  always_comb begin
    freeIdx  = '0;
    matchIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (freeVec[i])  freeIdx  = IDX_W'(i);
      if (matchVec[i]) matchIdx = IDX_W'(i);
    end
  end

  assign anyFree  = |freeVec;
  assign anyMatch = |matchVec;

  always_comb begin
    strobe.merge  = addValid && anyMatch;
    strobe.wrEn   = addValid && (anyMatch || anyFree);
    strobe.setOvf = addValid && !anyMatch && !anyFree;
    wrIdx         = anyMatch ? matchIdx : freeIdx;
  end

  assign stall = chkValid && (|hitVec);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          ovfFlag <= 1'b0;
    else if (strobe.setOvf)             ovfFlag <= 1'b1;
    else if (ovfWrEn && !ovfWrData)     ovfFlag <= 1'b0;
  end

  // R3: no stall without a check request.
  p_stall_needs_check_r3: assert property (@(posedge clk) disable iff (!rstN)
    !chkValid |-> !stall);

  // R7: a new handle arriving at a full table raises the flag.
  p_ovf_on_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    (addValid && (freeVec == '0) && (matchVec == '0)) |=> ovfFlag);

  // R8: the flag only drops on a clearing write.
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !(ovfWrEn && !ovfWrData)) |=> ovfFlag);

  // R4: a merge never raises the flag by itself.
  p_merge_no_ovf_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!ovfFlag && addValid && (matchVec != '0)) |=> !ovfFlag);

endmodule

// File: rtl/res_hazard_table.sv
module res_hazard_table
  import rht_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int BASE_W  = 64,
  parameter int TS_W    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addValid,
  input  logic [BASE_W-1:0] addBase,
  input  logic              addWrite,
  input  logic [TS_W-1:0]   addTs,
  input  logic              chkValid,
  input  logic [BASE_W-1:0] chkBase,
  input  logic              chkWrite,
  input  logic              clrValid,
  input  logic [TS_W-1:0]   clrTs,
  input  logic              ovfWrEn,
  input  logic              ovfWrData,
  output logic              stall,
  output logic              ovfFlag
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  rhtStrobe_t         strobe;
  logic [IDX_W-1:0]   wrIdx;
  logic [ENTRIES-1:0] freeVec;
  logic [ENTRIES-1:0] matchVec;
  logic [ENTRIES-1:0] hitVec;

  rht_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .addValid (addValid),
    .chkValid (chkValid),
    .ovfWrEn  (ovfWrEn),
    .ovfWrData(ovfWrData),
    .freeVec  (freeVec),
    .matchVec (matchVec),
    .hitVec   (hitVec),
    .strobe   (strobe),
    .wrIdx    (wrIdx),
    .stall    (stall),
    .ovfFlag  (ovfFlag)
  );

  rht_store #(.ENTRIES(ENTRIES), .BASE_W(BASE_W), .TS_W(TS_W)) u_store (
    .clk     (clk),
    .rstN    (rstN),
    .addBase (addBase),
    .addWrite(addWrite),
    .addTs   (addTs),
    .chkBase (chkBase),
    .chkWrite(chkWrite),
    .clrValid(clrValid),
    .clrTs   (clrTs),
    .strobe  (strobe),
    .wrIdx   (wrIdx),
    .freeVec (freeVec),
    .matchVec(matchVec),
    .hitVec  (hitVec)
  );

endmodule

// File: tb/sim_res_hazard_table.sv
`timescale 1ns/1ps
module sim_res_hazard_table;
  localparam int BW = 64;
  localparam int TW = 32;

  logic clk = 1'b0;
  logic rstN;
  logic addValid, addWrite, chkValid, chkWrite, clrValid, ovfWrEn, ovfWrData;
  logic [BW-1:0] addBase, chkBase;
  logic [TW-1:0] addTs, clrTs;
  logic stall, ovfFlag;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  bit    qStall[$];
  bit    qOvf[$];
  string qTag[$];

  always #2.5 clk = ~clk;

  res_hazard_table u0 (
    .clk(clk), .rstN(rstN),
    .addValid(addValid), .addBase(addBase), .addWrite(addWrite), .addTs(addTs),
    .chkValid(chkValid), .chkBase(chkBase), .chkWrite(chkWrite),
    .clrValid(clrValid), .clrTs(clrTs),
    .ovfWrEn(ovfWrEn), .ovfWrData(ovfWrData),
    .stall(stall), .ovfFlag(ovfFlag)
  );

  task automatic idleIns();
    addValid = 0; addWrite = 0; addBase = '0; addTs = '0;
    chkValid = 0; chkWrite = 0; chkBase = '0;
    clrValid = 0; clrTs = '0;
    ovfWrEn = 0; ovfWrData = 0;
  endtask

  task automatic setAdd(input logic [BW-1:0] b, input bit w, input logic [TW-1:0] t);
    addValid = 1; addBase = b; addWrite = w; addTs = t;
  endtask

  task automatic setChk(input logic [BW-1:0] b, input bit w);
    chkValid = 1; chkBase = b; chkWrite = w;
  endtask

  task automatic setClr(input logic [TW-1:0] t);
    clrValid = 1; clrTs = t;
  endtask

  task automatic setOvfWr(input bit d);
    ovfWrEn = 1; ovfWrData = d;
  endtask

  // Driver: queue the expectation for the current cycle, then advance.
  task automatic cycle(input bit eStall, input bit eOvf, input string tag);
    qStall.push_back(eStall);
    qOvf.push_back(eOvf);
    qTag.push_back(tag);
    @(negedge clk);
    idleIns();
  endtask

  // Monitor: samples mid low phase, well away from the rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #1.5;
      while (qTag.size() > 0) begin
        bit es, eo;
        string tg;
        es = qStall.pop_front();
        eo = qOvf.pop_front();
        tg = qTag.pop_front();
        vectors++;
        if (stall !== es || ovfFlag !== eo) begin
          errors++;
          $display("FAIL %s: stall=%b ovfFlag=%b expected stall=%b ovfFlag=%b",
                   tg, stall, ovfFlag, es, eo);
        end
      end
    end
  end

  initial begin
    #200us;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  localparam logic [BW-1:0] BASE_A = 64'h100;
  localparam logic [BW-1:0] BASE_C = 64'h8000_0000_0000_0100;

  initial begin
    rstN = 0;
    idleIns();
    repeat (3) @(negedge clk);
    rstN = 1;

    setChk(64'h5, 1);        cycle(0, 0, "R1 empty table after reset");
    setAdd(BASE_A, 0, 10);   cycle(0, 0, "R1 add read entry");
    setChk(BASE_A, 0);       cycle(0, 0, "R3 read against read entry");
    setChk(BASE_A, 1);       cycle(1, 0, "R2 write against read entry");
    setChk(64'h200, 1);      cycle(0, 0, "R3 unmatched base");
    setAdd(BASE_C, 1, 20);   cycle(0, 0, "R2 add write entry");
    setChk(BASE_C, 0);       cycle(1, 0, "R2 read against write entry");
    setChk(BASE_A, 0);       cycle(0, 0, "R9 top bit differs");
    setAdd(BASE_A, 1, 30);   cycle(0, 0, "R4 merge add");
    setChk(BASE_A, 0);       cycle(1, 0, "R4 merged write flag");
    setClr(25); setChk(BASE_C, 0); cycle(0, 0, "R6 clear applied before check");
    setChk(BASE_A, 0);       cycle(1, 0, "R4 refreshed timestamp survives clear");
    setChk(BASE_C, 1);       cycle(0, 0, "R5 older entry removed");
    setClr(30);              cycle(0, 0, "R5 clear at equal timestamp");
    setChk(BASE_A, 1);       cycle(0, 0, "R5 equal timestamp removed");

    for (int i = 0; i < 16; i++) begin
      setAdd(64'h1000 + 64'(i), 0, 32'(100 + i));
      cycle(0, 0, "R7 fill table");
    end
    setAdd(64'h1000, 1, 150); cycle(0, 0, "R4 merge into full table");
    cycle(0, 0, "R4 merge leaves overflow clear");
    setAdd(64'h2000, 1, 160); cycle(0, 0, "R7 add to full table");
    setChk(64'h2000, 1);      cycle(0, 1, "R7 overflow set and entry dropped");
    setOvfWr(1);              cycle(0, 1, "R8 write of one");
    cycle(0, 1, "R8 write of one ignored");
    setOvfWr(0);              cycle(0, 1, "R8 clearing write");
    cycle(0, 0, "R8 flag cleared");
    setAdd(64'h2001, 0, 161); setOvfWr(0); cycle(0, 0, "R8 overflow with clearing write");
    cycle(0, 1, "R8 overflow wins");
    setOvfWr(0);              cycle(0, 1, "R8 clearing write again");
    cycle(0, 0, "R8 flag cleared again");
    setAdd(64'h3000, 1, 170); setClr(200); cycle(0, 0, "R7 add with same-cycle clear");
    setChk(64'h3000, 0);      cycle(0, 1, "R7 occupancy judged before clear");
    setChk(64'h1000, 1);      cycle(0, 1, "R5 whole table cleared");
    setOvfWr(0);              cycle(0, 1, "R8 clear before reuse");
    setAdd(64'h4000, 1, 5);   cycle(0, 0, "R2 add after emptying");
    setChk(64'h4000, 0);      cycle(1, 0, "R2 new entry visible");

    @(negedge clk);
    #3;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule